// File: doc/BRIEF.md
# Flash Access Protection Gate

This block sits in front of the program flash and data EEPROM controllers and decides, request by request, whether a read or a write may proceed. Each request carries a byte address, a read/write flag and an access mode: application software, in-circuit programming, or debug. The answer is a single-cycle grant or deny that depends only on the current request and the block's protection state.

Two layers of protection are combined. The first is a per-area write lock. It opens only after software writes a two-byte key sequence, and it never opens the boot-code region at the bottom of program flash. The size of that region is set in whole 512-byte pages. The second layer is a read-out lock. While it is set, programming and debug accesses to either memory are refused. Any attempt to change the read-out lock raises a one-cycle mass-erase request. The erase itself is carried out by the flash controller, and the option storage cells that hold the read-out flag and the boot size live outside this block.

Top module: `flash_guard`

## Requirements
- R1: After reset both write locks are closed, `prog_unlocked`, `data_unlocked`, `wp_violation` and `erase_req` are 0, and every write to either memory is denied.
- R2: A key write with `key_sel`=0 of 0x56 followed by one of 0xAE sets `prog_unlocked` on the edge of the second key write. After that, writes to program flash above the boot region are granted.
- R3: A key write with `key_sel`=1 of 0xAE followed by one of 0x56 sets `data_unlocked`. After that, writes to data EEPROM are granted.
- R4: A wrong key value, or the right values in the wrong order, locks that area until the next reset. A correct sequence written later does not unlock it.
- R5: Writes to program flash addresses from `PROG_BASE` up to `PROG_BASE + 512*ubc_pages - 1` are always denied, even when the area is unlocked. A `ubc_pages` value of 0 means there is no boot region.
- R6: While `rop_active` is 1, reads and writes in mode 1 (in-circuit programming) and in modes 2 and 3 (debug) are denied for both memories.
- R7: Reads in mode 0 (application) of any program flash or data EEPROM address are granted, whatever the value of `rop_active`.
- R8: A pulse on `rop_change_req` produces a one-cycle `erase_req` on the following clock edge.
- R9: A pulse on `relock_prog` or `relock_data` clears the matching unlocked flag and denies writes to that area again. A new correct key sequence reopens it.
- R10: A denied write sets `wp_violation` on the next edge, and the flag stays at 1 until reset.
- R11: Addresses outside both memory windows are denied. While `req_valid` is 1 exactly one of `grant` and `deny` is 1, and while it is 0 both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the request |
| req_mode | input | 2 | 0 application, 1 in-circuit programming, 2/3 debug |
| key_we | input | 1 | Key byte write strobe |
| key_sel | input | 1 | Key target: 0 program flash, 1 data EEPROM |
| key_data | input | 8 | Key byte value |
| relock_prog | input | 1 | Close the program flash write lock |
| relock_data | input | 1 | Close the data EEPROM write lock |
| ubc_pages | input | UBC_W | Boot region size in 512-byte pages |
| rop_active | input | 1 | Read-out lock currently set |
| rop_change_req | input | 1 | Attempt to change the read-out lock |
| grant | output | 1 | Request allowed (combinational) |
| deny | output | 1 | Request refused (combinational) |
| erase_req | output | 1 | One-cycle mass-erase request |
| prog_unlocked | output | 1 | Program flash write lock is open |
| data_unlocked | output | 1 | Data EEPROM write lock is open |
| wp_violation | output | 1 | Sticky flag: a write was denied |

## Verification
The bench uses the default parameters: a 16-bit address, program flash at 0x8000 filling the top 32 KB, data EEPROM of 1 KB at 0x4000, and a 7-bit boot size field. With these values the boot region can cover anywhere from zero pages to the whole program space, so both the empty-region case and the full-region case can be driven. Every address class is reachable: below the data window, between the two windows, and at each window edge. Random requests spread over all four modes, both read-out states and all boot sizes are compared against a bench model, both with the locks open and with them closed.

// File: rtl/flash_guard_pkg.sv
// Package: shared encodings for the flash access protection gate.
// Assumes: mode 3 is handled like debug.
package flash_guard_pkg;

    typedef enum logic [1:0] {
        MODE_APP = 2'd0,
        MODE_ICP = 2'd1,
        MODE_DBG = 2'd2,
        MODE_RSV = 2'd3
    } acc_mode_e;

    typedef enum logic [1:0] {
        KS_CLOSED  = 2'd0,
        KS_HALF    = 2'd1,
        KS_OPEN    = 2'd2,
        KS_BLOCKED = 2'd3
    } key_state_e;

endpackage

// File: rtl/key_unlock_fsm.sv
// key_unlock_fsm: two-step key sequence that opens one memory area for writes.
// The first key write must equal FIRST_KEY and the next must equal SECOND_KEY.
// Any other value locks the area out until reset. relock closes an open area.
// Assumes key_wr is already qualified by the area select.
module key_unlock_fsm
    import flash_guard_pkg::*;
#(
    parameter logic [7:0] FIRST_KEY  = 8'h56,
    parameter logic [7:0] SECOND_KEY = 8'hAE
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       key_wr,
    input  logic [7:0] key_val,
    input  logic       relock,
    output logic       unlocked
);

    key_state_e state_q, state_d;

    // Next-state logic for the key sequence.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KS_CLOSED: begin
                if (key_wr) state_d = (key_val == FIRST_KEY) ? KS_HALF : KS_BLOCKED;
            end
            KS_HALF: begin
                if (relock)      state_d = KS_CLOSED;
                else if (key_wr) state_d = (key_val == SECOND_KEY) ? KS_OPEN : KS_BLOCKED;
            end
            KS_OPEN: begin
                if (relock) state_d = KS_CLOSED;
            end
            KS_BLOCKED: state_d = KS_BLOCKED;
            default:    state_d = KS_BLOCKED;
        endcase
    end

    // State register, synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= KS_CLOSED;
        else        state_q <= state_d;
    end

    assign unlocked = (state_q == KS_OPEN);

endmodule

// File: rtl/region_decode.sv
// region_decode: classifies a byte address as program flash, data EEPROM,
// boot region (a prefix of program flash), or none of them.
// Assumes the windows do not overlap and fit in 32-bit arithmetic.
module region_decode #(
    parameter int          ADDR_W     = 16,
    parameter int          UBC_W      = 7,
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned PROG_BASE  = 32'h8000,
    parameter int unsigned PROG_SIZE  = 32768,
    parameter int unsigned DATA_BASE  = 32'h4000,
    parameter int unsigned DATA_SIZE  = 1024
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [UBC_W-1:0]  ubc_pages,
    output logic              in_prog,
    output logic              in_data,
    output logic              in_boot
);

    localparam int unsigned PROG_END = PROG_BASE + PROG_SIZE;
    localparam int unsigned DATA_END = DATA_BASE + DATA_SIZE;

    int unsigned a_ext;
    int unsigned boot_end;

    // Window compare on a zero-extended address.
    always_comb begin
        a_ext    = 32'(addr);
        boot_end = PROG_BASE + 32'(ubc_pages) * PAGE_BYTES;
        in_prog  = (a_ext >= PROG_BASE) && (a_ext < PROG_END);
        in_data  = (a_ext >= DATA_BASE) && (a_ext < DATA_END);
        in_boot  = in_prog && (a_ext < boot_end);
    end

endmodule

// File: rtl/access_arbiter.sv
// access_arbiter: combinational grant/deny decision for one request.
// Application reads always pass. The read-out lock refuses programming and
// debug accesses. Writes also need the area unlocked and must miss the boot region.
module access_arbiter
    import flash_guard_pkg::*;
(
    input  logic       req_valid,
    input  logic       req_write,
    input  logic [1:0] req_mode,
    input  logic       in_prog,
    input  logic       in_data,
    input  logic       in_boot,
    input  logic       rop_active,
    input  logic       prog_open,
    input  logic       data_open,
    output logic       grant,
    output logic       deny
);

    logic is_app;
    logic allow;

    // Policy evaluation.
    always_comb begin
        is_app = (acc_mode_e'(req_mode) == MODE_APP);
        allow  = 1'b0;
        if (in_prog || in_data) begin
            if (!is_app && rop_active)  allow = 1'b0;
            else if (!req_write)        allow = 1'b1;
            else if (in_prog)           allow = prog_open && !in_boot;
            else                        allow = data_open;
        end
        grant = req_valid && allow;
        deny  = req_valid && !allow;
    end

endmodule

// File: rtl/flash_guard.sv
// flash_guard: access-control gate for program flash and data EEPROM.
// Holds one key unlock FSM per area, decodes the address windows, arbitrates
// each request, keeps a sticky write-violation flag and raises a one-cycle
// erase request when a change of the read-out lock is attempted.
// Assumes rop_active and ubc_pages come from stable option storage.
module flash_guard #(
    parameter int          ADDR_W     = 16,
    parameter int          UBC_W      = 7,
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned PROG_BASE  = 32'h8000,
    parameter int unsigned PROG_SIZE  = 32768,
    parameter int unsigned DATA_BASE  = 32'h4000,
    parameter int unsigned DATA_SIZE  = 1024,
    parameter logic [7:0]  KEY_A      = 8'h56,
    parameter logic [7:0]  KEY_B      = 8'hAE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [1:0]        req_mode,
    input  logic              key_we,
    input  logic              key_sel,
    input  logic [7:0]        key_data,
    input  logic              relock_prog,
    input  logic              relock_data,
    input  logic [UBC_W-1:0]  ubc_pages,
    input  logic              rop_active,
    input  logic              rop_change_req,
    output logic              grant,
    output logic              deny,
    output logic              erase_req,
    output logic              prog_unlocked,
    output logic              data_unlocked,
    output logic              wp_violation
);

    localparam int N_AREAS = 2;

    logic [N_AREAS-1:0] area_open;
    logic [N_AREAS-1:0] area_relock;
    logic               in_prog, in_data, in_boot;

    assign area_relock = {relock_data, relock_prog};

    // One unlock FSM per area; the key order is swapped for the data area.
    for (genvar g = 0; g < N_AREAS; g++) begin : g_area
        localparam logic [7:0] K1 = (g == 0) ? KEY_A : KEY_B;
        localparam logic [7:0] K2 = (g == 0) ? KEY_B : KEY_A;
        key_unlock_fsm #(
            .FIRST_KEY  (K1),
            .SECOND_KEY (K2)
        ) u_key (
            .clk      (clk),
            .rst_n    (rst_n),
            .key_wr   (key_we && (key_sel == 1'(g))),
            .key_val  (key_data),
            .relock   (area_relock[g]),
            .unlocked (area_open[g])
        );
    end

    region_decode #(
        .ADDR_W     (ADDR_W),
        .UBC_W      (UBC_W),
        .PAGE_BYTES (PAGE_BYTES),
        .PROG_BASE  (PROG_BASE),
        .PROG_SIZE  (PROG_SIZE),
        .DATA_BASE  (DATA_BASE),
        .DATA_SIZE  (DATA_SIZE)
    ) u_dec (
        .addr      (req_addr),
        .ubc_pages (ubc_pages),
        .in_prog   (in_prog),
        .in_data   (in_data),
        .in_boot   (in_boot)
    );

    access_arbiter u_arb (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_mode   (req_mode),
        .in_prog    (in_prog),
        .in_data    (in_data),
        .in_boot    (in_boot),
        .rop_active (rop_active),
        .prog_open  (area_open[0]),
        .data_open  (area_open[1]),
        .grant      (grant),
        .deny       (deny)
    );

    // Sticky violation flag and registered erase pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_violation <= 1'b0;
            erase_req    <= 1'b0;
        end else begin
            if (deny && req_write) wp_violation <= 1'b1;
            erase_req <= rop_change_req;
        end
    end

    assign prog_unlocked = area_open[0];
    assign data_unlocked = area_open[1];

endmodule

// File: rtl/flash_guard_sva.sv
// flash_guard_sva: property checker bound to flash_guard.
// Observes ports only; the window bounds come from the same parameters.
module flash_guard_sva #(
    parameter int          ADDR_W     = 16,
    parameter int          UBC_W      = 7,
    parameter int unsigned PAGE_BYTES = 512,
    parameter int unsigned PROG_BASE  = 32'h8000,
    parameter int unsigned PROG_SIZE  = 32768,
    parameter int unsigned DATA_BASE  = 32'h4000,
    parameter int unsigned DATA_SIZE  = 1024,
    parameter logic [7:0]  KEY_A      = 8'h56,
    parameter logic [7:0]  KEY_B      = 8'hAE
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [1:0]        req_mode,
    input logic              key_we,
    input logic              key_sel,
    input logic [7:0]        key_data,
    input logic              relock_prog,
    input logic              relock_data,
    input logic [UBC_W-1:0]  ubc_pages,
    input logic              rop_active,
    input logic              rop_change_req,
    input logic              grant,
    input logic              deny,
    input logic              erase_req,
    input logic              prog_unlocked,
    input logic              data_unlocked,
    input logic              wp_violation
);

    int unsigned a_chk;
    logic        chk_boot, chk_region;

    // Independent address classification for the properties.
    always_comb begin
        a_chk      = 32'(req_addr);
        chk_boot   = (a_chk >= PROG_BASE) && (a_chk < PROG_BASE + 32'(ubc_pages) * PAGE_BYTES);
        chk_region = ((a_chk >= PROG_BASE) && (a_chk < PROG_BASE + PROG_SIZE)) ||
                     ((a_chk >= DATA_BASE) && (a_chk < DATA_BASE + DATA_SIZE));
    end

    AST_ONE_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> (grant ^ deny)); // R11
    AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> (!grant && !deny)); // R11
    AST_BOOT_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && chk_boot) |-> !grant); // R5
    AST_ROP_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && rop_active && req_mode != 2'd0) |-> !grant); // R6
    AST_APP_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && req_mode == 2'd0 && chk_region) |-> grant); // R7
    AST_ERASE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rop_change_req |=> erase_req); // R8
    AST_ERASE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        erase_req |-> $past(rop_change_req)); // R8
    AST_WPV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        wp_violation |=> wp_violation); // R10
    AST_PROG_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_unlocked) |-> $past(key_we && !key_sel && key_data == KEY_B)); // R2
    AST_DATA_OPEN_KEY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(data_unlocked) |-> $past(key_we && key_sel && key_data == KEY_A)); // R3
    AST_RELOCK_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        relock_prog |=> !prog_unlocked); // R9

endmodule

bind flash_guard flash_guard_sva #(
    .ADDR_W     (ADDR_W),
    .UBC_W      (UBC_W),
    .PAGE_BYTES (PAGE_BYTES),
    .PROG_BASE  (PROG_BASE),
    .PROG_SIZE  (PROG_SIZE),
    .DATA_BASE  (DATA_BASE),
    .DATA_SIZE  (DATA_SIZE),
    .KEY_A      (KEY_A),
    .KEY_B      (KEY_B)
) sva_i (.*);

// File: tb/flash_guard_tb_top.sv
// Self-checking bench for flash_guard: directed corner cases plus seeded random requests.
module flash_guard_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [15:0] req_addr = '0;
    logic [1:0]  req_mode = '0;
    logic        key_we = 1'b0, key_sel = 1'b0;
    logic [7:0]  key_data = '0;
    logic        relock_prog = 1'b0, relock_data = 1'b0;
    logic [6:0]  ubc_pages = '0;
    logic        rop_active = 1'b0, rop_change_req = 1'b0;
    logic        grant, deny, erase_req, prog_unlocked, data_unlocked, wp_violation;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_guard dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_mode(req_mode), .key_we(key_we), .key_sel(key_sel),
        .key_data(key_data), .relock_prog(relock_prog), .relock_data(relock_data),
        .ubc_pages(ubc_pages), .rop_active(rop_active), .rop_change_req(rop_change_req),
        .grant(grant), .deny(deny), .erase_req(erase_req), .prog_unlocked(prog_unlocked),
        .data_unlocked(data_unlocked), .wp_violation(wp_violation)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference decision computed from the requirements.
    function automatic bit exp_grant(bit wr, int unsigned a, int md, bit rop,
                                     bit pu, bit du, int unsigned ubc);
        bit in_p = (a >= 32'h8000) && (a < 32'h10000);
        bit in_d = (a >= 32'h4000) && (a < 32'h4400);
        if (!in_p && !in_d) return 1'b0;
        if (rop && md != 0) return 1'b0;
        if (!wr) return 1'b1;
        if (in_p) return pu && (a >= 32'h8000 + ubc * 512);
        return du;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0; key_we = 1'b0; relock_prog = 1'b0; relock_data = 1'b0;
        rop_change_req = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic key(bit sel, logic [7:0] v);
        @(negedge clk);
        key_we = 1'b1; key_sel = sel; key_data = v;
        @(negedge clk);
        key_we = 1'b0;
    endtask

    // Apply a request and return grant after the combinational path settles.
    task automatic probe(bit wr, logic [15:0] a, logic [1:0] md, output logic g);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_mode = md;
        #1 g = grant;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic g;
        void'($urandom(32'd2024));
        do_reset();
        #1;
        check("R1 prog_unlocked", prog_unlocked, 0);
        check("R1 data_unlocked", data_unlocked, 0);
        check("R1 wp_violation", wp_violation, 0);
        check("R1 erase_req", erase_req, 0);
        probe(1, 16'h9000, 2'd0, g); check("R1 prog write locked", g, 0);
        #1 check("R10 wpv set", wp_violation, 1);
        probe(0, 16'h9000, 2'd0, g);
        #1 check("R10 wpv sticky", wp_violation, 1);
        probe(1, 16'h4010, 2'd0, g); check("R1 data write locked", g, 0);

        do_reset(); #1 check("R10 wpv cleared by reset", wp_violation, 0);
        key(0, 8'h56); key(0, 8'hAE);
        #1 check("R2 prog unlocked", prog_unlocked, 1);
        check("R2 data still locked", data_unlocked, 0);
        ubc_pages = 7'd0;
        probe(1, 16'h9000, 2'd0, g); check("R2 prog write", g, 1);
        probe(1, 16'h8000, 2'd0, g); check("R5 ubc0 base write", g, 1);
        ubc_pages = 7'd4;
        probe(1, 16'h87FF, 2'd0, g); check("R5 last boot byte", g, 0);
        probe(1, 16'h8800, 2'd0, g); check("R5 first free byte", g, 1);
        ubc_pages = 7'd64;
        probe(1, 16'hFFFF, 2'd0, g); check("R5 full boot", g, 0);
        ubc_pages = 7'd0;

        key(1, 8'hAE); key(1, 8'h56);
        #1 check("R3 data unlocked", data_unlocked, 1);
        probe(1, 16'h4010, 2'd0, g); check("R3 data write", g, 1);
        probe(1, 16'h43FF, 2'd0, g); check("R3 data top", g, 1);
        probe(1, 16'h4400, 2'd0, g); check("R11 past data top", g, 0);

        @(negedge clk); relock_prog = 1'b1; @(negedge clk); relock_prog = 1'b0;
        #1 check("R9 relock prog", prog_unlocked, 0);
        probe(1, 16'h9000, 2'd0, g); check("R9 write after relock", g, 0);
        key(0, 8'h56); key(0, 8'hAE);
        #1 check("R9 reopen", prog_unlocked, 1);
        @(negedge clk); relock_data = 1'b1; @(negedge clk); relock_data = 1'b0;
        #1 check("R9 relock data", data_unlocked, 0);
        key(1, 8'hAE); key(1, 8'h56);

        rop_active = 1'b1;
        probe(0, 16'h9000, 2'd1, g); check("R6 icp read", g, 0);
        probe(1, 16'h4010, 2'd2, g); check("R6 debug write", g, 0);
        probe(0, 16'h4010, 2'd3, g); check("R6 mode3 read", g, 0);
        probe(0, 16'h9000, 2'd0, g); check("R7 app read prog rop", g, 1);
        probe(0, 16'h4000, 2'd0, g); check("R7 app read data rop", g, 1);
        rop_active = 1'b0;
        probe(0, 16'h9000, 2'd1, g); check("R6 icp read no rop", g, 1);

        probe(0, 16'h2000, 2'd0, g); check("R11 outside read", g, 0);
        @(negedge clk); #1 check("R11 idle grant", grant, 0); check("R11 idle deny", deny, 0);

        @(negedge clk); rop_change_req = 1'b1; @(negedge clk); rop_change_req = 1'b0;
        #1 check("R8 erase pulse", erase_req, 1);
        @(negedge clk); #1 check("R8 erase one cycle", erase_req, 0);

        // Random requests with both areas open.
        for (int i = 0; i < 400; i++) begin
            int unsigned a, u, kind;
            int md; bit wr, rp;
            kind = $urandom_range(0, 2);
            a = (kind == 0) ? $urandom_range(32'h8000, 32'hFFFF) :
                (kind == 1) ? $urandom_range(32'h3F00, 32'h44FF) : $urandom_range(0, 32'hFFFF);
            u = $urandom_range(0, 64); md = $urandom_range(0, 3);
            wr = 1'($urandom_range(0, 1)); rp = 1'($urandom_range(0, 1));
            ubc_pages = 7'(u); rop_active = rp;
            probe(wr, 16'(a), 2'(md), g);
            check("R5 R6 R7 random open", g, exp_grant(wr, a, md, rp, 1, 1, u));
        end
        rop_active = 1'b0;

        // Key lockout.
        do_reset();
        key(0, 8'hAE); key(0, 8'h56); key(0, 8'hAE);
        #1 check("R4 prog lockout", prog_unlocked, 0);
        key(1, 8'h56); key(1, 8'hAE); key(1, 8'h56);
        #1 check("R4 data lockout", data_unlocked, 0);
        key(1, 8'h12);
        probe(1, 16'h4010, 2'd0, g); check("R4 data write lockout", g, 0);
        do_reset();
        key(0, 8'h56); key(0, 8'hAE);
        #1 check("R4 unlock after reset", prog_unlocked, 1);

        // Random requests with both areas locked.
        do_reset();
        for (int i = 0; i < 200; i++) begin
            int unsigned a, u;
            int md; bit wr, rp;
            a = $urandom_range(32'h3000, 32'hFFFF); u = $urandom_range(0, 64);
            md = $urandom_range(0, 3); wr = 1'($urandom_range(0, 1)); rp = 1'($urandom_range(0, 1));
            ubc_pages = 7'(u); rop_active = rp;
            probe(wr, 16'(a), 2'(md), g);
            check("R1 R7 random locked", g, exp_grant(wr, a, md, rp, 0, 0, u));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule